// File: doc/BRIEF.md
# Write-Through Valid/Invalid Snooping Cache Controller

This block keeps coherence state for a small direct-mapped private cache that writes through to memory. Every line is either invalid or holds a valid copy. The owning core presents one read or write at a time on a valid/ready handshake. The controller checks the tag and valid state for that request. It then either answers at once or places a transaction on a shared snoop bus and waits for the arbiter's grant and the completion of that transaction.

The controller also watches every transaction on the shared bus. A word write or read-exclusive that another master issues, and whose address matches a valid local line, quietly drops that line to invalid. Transactions that carry the controller's own master ID are not treated as snoops. The data payload of a processor write is passed through to the bus as a single word. Memory and arbitration live outside the block.

Top module: `wt_snoop_ctrl`

## Requirements
- R1: For one or more cycles with `rst` high, and afterwards until the first request, every line is invalid, `cpu_ready` and `bus_req` are low and `bus_cmd` is 2'b00 (none).
- R2: A read whose line is invalid or holds another tag raises `bus_req` one cycle after it is seen, with `bus_cmd` = 2'b01 (read) and `bus_addr` equal to the request address. On completion the line holds that tag and is valid.
- R3: A write that misses raises `bus_req` with `bus_cmd` = 2'b10 (read-exclusive). On completion the line is valid with the request tag.
- R4: A read that hits a valid line with a matching tag raises `cpu_ready` in the next cycle and causes no bus request.
- R5: A write that hits issues `bus_cmd` = 2'b11 (word write) with `bus_wdata` equal to the write data, and the line stays valid.
- R6: A bus transaction with `snp_master` different from SELF_ID, `snp_cmd` 2'b11 or 2'b10, and an address whose index and tag match a valid line makes that line invalid at the next edge.
- R7: A snooped read (2'b01), or a snooped write whose tag differs from the stored one, leaves every line unchanged.
- R8: A snooped transaction whose `snp_master` equals SELF_ID leaves every line unchanged.
- R9: While a transaction waits, `bus_req`, `bus_cmd` and `bus_addr` hold steady. The transaction completes only in a cycle with both `bus_gnt` and `bus_done` high. `cpu_ready` rises in the following cycle, together with `bus_req` falling and `bus_cmd` returning to 2'b00.
- R10: Snoop invalidations apply while a local request is waiting. A snoop that kills the line being looked up in the same cycle turns that lookup into a miss.
- R11: `cpu_ready` is a one-cycle pulse, and exactly one pulse answers each request. The core drops `cpu_valid` after it sees that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Core request present, held until `cpu_ready` |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus request, held until completion |
| bus_cmd | output | 2 | 00 none, 01 read, 10 read-exclusive, 11 word write |
| bus_addr | output | ADDR_W | Address of the issued transaction |
| bus_wdata | output | DATA_W | Word carried by a word write |
| bus_gnt | input | 1 | Arbiter grant |
| bus_done | input | 1 | Transaction completes (counted only with grant) |
| snp_valid | input | 1 | A transaction is visible on the bus |
| snp_cmd | input | 2 | Command of the visible transaction |
| snp_addr | input | ADDR_W | Address of the visible transaction |
| snp_master | input | ID_W | Master ID of the visible transaction |

## Verification
The bench builds the block with ADDR_W=12 and IDX_W=3, giving eight lines with a nine-bit tag, and with ID_W=2 and SELF_ID=1. With these values, two addresses that share an index but differ in tag are easy to pick, so replacement misses and snoops with a wrong tag come within reach. The grant and done delays can be set separately. This lets the bench hold a request waiting for many cycles, raise grant without done, and land a foreign invalidation inside that wait or in the very cycle of a lookup.

// File: rtl/wt_snoop_pkg.sv
package wt_snoop_pkg;
  typedef enum logic [1:0] {
    CMD_NONE  = 2'b00,
    CMD_READ  = 2'b01,
    CMD_RDX   = 2'b10,
    CMD_WRITE = 2'b11
  } bus_cmd_e;

  typedef enum logic {
    CS_IDLE = 1'b0,
    CS_BUS  = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/wt_snoop_filter.sv
module wt_snoop_filter #(
  parameter int ADDR_W  = 12,
  parameter int IDX_W   = 3,
  parameter int ID_W    = 2,
  parameter int SELF_ID = 1,
  localparam int TAG_W  = ADDR_W - IDX_W
) (
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [ID_W-1:0]   snp_master,
  output logic              kill_req,
  output logic [IDX_W-1:0]  kill_idx,
  output logic [TAG_W-1:0]  kill_tag
);
  import wt_snoop_pkg::*;

  logic foreign;
  logic exclusive;

  always_comb begin
    foreign   = (snp_master != ID_W'(SELF_ID));
    exclusive = (snp_cmd == CMD_WRITE) || (snp_cmd == CMD_RDX);
    kill_req  = snp_valid && foreign && exclusive;
    kill_idx  = snp_addr[IDX_W-1:0];
    kill_tag  = snp_addr[ADDR_W-1:IDX_W];
  end
endmodule

// File: rtl/wt_tag_store.sv
module wt_tag_store #(
  parameter int IDX_W = 3,
  parameter int TAG_W = 9,
  localparam int LINES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             kill_req,
  input  logic [IDX_W-1:0] kill_idx,
  input  logic [TAG_W-1:0] kill_tag,
  output logic [LINES-1:0] valid_vec
);
  logic [TAG_W-1:0] tag_mem [LINES];
  logic [LINES-1:0] valid_q;
  logic             snoop_hit;

  always_comb begin
    snoop_hit = kill_req && valid_q[kill_idx] && (tag_mem[kill_idx] == kill_tag);
    lk_hit    = valid_q[lk_idx] && (tag_mem[lk_idx] == lk_tag)
                && !(snoop_hit && (kill_idx == lk_idx));
    valid_vec = valid_q;
  end

  // tag memory: write-only on fill, no reset, so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (fill_en) tag_mem[fill_idx] <= fill_tag;
  end

  // valid bits: fill wins over a snoop kill on the same index
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      if (snoop_hit) valid_q[kill_idx] <= 1'b0;
      if (fill_en)   valid_q[fill_idx] <= 1'b1;
    end
  end

  assert_fill_sets_valid_R2: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> valid_q[$past(fill_idx)]);

  assert_snoop_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (snoop_hit && !(fill_en && fill_idx == kill_idx)) |=> !valid_q[$past(kill_idx)]);
endmodule

// File: rtl/wt_req_fsm.sv
module wt_req_fsm #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  input  logic              lk_hit,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic              bus_done,
  output logic              fill_en,
  output logic [IDX_W-1:0]  fill_idx,
  output logic [TAG_W-1:0]  fill_tag
);
  import wt_snoop_pkg::*;

  ctl_state_e state;
  bus_cmd_e   cmd_q;
  logic       finish;

  always_comb begin
    finish   = (state == CS_BUS) && bus_gnt && bus_done;
    fill_en  = finish;
    fill_idx = bus_addr[IDX_W-1:0];
    fill_tag = bus_addr[ADDR_W-1:IDX_W];
    bus_cmd  = cmd_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= CS_IDLE;
      cpu_ready <= 1'b0;
      bus_req   <= 1'b0;
      cmd_q     <= CMD_NONE;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      cpu_ready <= 1'b0;
      case (state)
        CS_IDLE: begin
          if (cpu_valid && !cpu_ready) begin
            if (!cpu_write && lk_hit) begin
              cpu_ready <= 1'b1;
            end else begin
              state     <= CS_BUS;
              bus_req   <= 1'b1;
              bus_addr  <= cpu_addr;
              bus_wdata <= cpu_wdata;
              if (!cpu_write)  cmd_q <= CMD_READ;
              else if (lk_hit) cmd_q <= CMD_WRITE;
              else             cmd_q <= CMD_RDX;
            end
          end
        end
        CS_BUS: begin
          if (finish) begin
            state     <= CS_IDLE;
            bus_req   <= 1'b0;
            cmd_q     <= CMD_NONE;
            cpu_ready <= 1'b1;
          end
        end
        default: state <= CS_IDLE;
      endcase
    end
  end

  assert_ready_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !(bus_gnt && bus_done)) |=>
      (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

  assert_hit_no_bus_R4: assert property (@(posedge clk) disable iff (rst)
    (state == CS_IDLE && cpu_valid && !cpu_ready && !cpu_write && lk_hit) |=>
      (cpu_ready && !bus_req));

  assert_cmd_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !bus_req |-> (bus_cmd == CMD_NONE));
endmodule

// File: rtl/wt_snoop_ctrl.sv
module wt_snoop_ctrl #(
  parameter int ADDR_W  = 12,
  parameter int IDX_W   = 3,
  parameter int DATA_W  = 32,
  parameter int ID_W    = 2,
  parameter int SELF_ID = 1,
  localparam int TAG_W  = ADDR_W - IDX_W,
  localparam int LINES  = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic              bus_done,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [ID_W-1:0]   snp_master
);
  logic             kill_req;
  logic [IDX_W-1:0] kill_idx;
  logic [TAG_W-1:0] kill_tag;
  logic             lk_hit;
  logic             fill_en;
  logic [IDX_W-1:0] fill_idx;
  logic [TAG_W-1:0] fill_tag;
  logic [LINES-1:0] valid_vec;

  wt_snoop_filter #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ID_W(ID_W), .SELF_ID(SELF_ID)) u_filter (
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_master(snp_master),
    .kill_req(kill_req), .kill_idx(kill_idx), .kill_tag(kill_tag)
  );

  wt_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst),
    .lk_idx(cpu_addr[IDX_W-1:0]), .lk_tag(cpu_addr[ADDR_W-1:IDX_W]), .lk_hit(lk_hit),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag),
    .kill_req(kill_req), .kill_idx(kill_idx), .kill_tag(kill_tag),
    .valid_vec(valid_vec)
  );

  wt_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst),
    .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .lk_hit(lk_hit),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_gnt(bus_gnt), .bus_done(bus_done),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag)
  );

  assert_own_snoop_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && snp_master == ID_W'(SELF_ID) && !fill_en) |=> (valid_vec == $past(valid_vec)));

  assert_snoop_read_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && snp_cmd == 2'b01 && !fill_en) |=> (valid_vec == $past(valid_vec)));
endmodule

// File: tb/tb_wt_snoop_ctrl.sv
module tb_wt_snoop_ctrl;
  localparam int ADDR_W = 12;
  localparam int IDX_W  = 3;
  localparam int DATA_W = 32;
  localparam int ID_W   = 2;
  localparam int SELF   = 1;
  localparam int LINES  = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_valid = 0, cpu_write = 0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic cpu_ready, bus_req;
  logic [1:0] bus_cmd;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic bus_gnt = 0, bus_done = 0;
  logic snp_valid = 0;
  logic [1:0] snp_cmd = 0;
  logic [ADDR_W-1:0] snp_addr = '0;
  logic [ID_W-1:0] snp_master = '0;

  always #10 clk = ~clk;

  wt_snoop_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .ID_W(ID_W), .SELF_ID(SELF)) dut (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .bus_req(bus_req), .bus_cmd(bus_cmd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_gnt(bus_gnt), .bus_done(bus_done),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_master(snp_master)
  );

  // reference model state
  bit m_valid [LINES];
  int m_tag [LINES];
  bit m_busy = 0, m_ready = 0, m_req = 0;
  int m_cmd = 0, m_addr = 0;
  logic [DATA_W-1:0] m_wdata = '0;

  int vectors = 0, errors = 0;
  string cur_req = "R1";
  int gnt_dly = 1, done_dly = 1, resp_cnt = 0;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_valid[i]) m_valid[i] = 0;
      m_busy = 0; m_ready = 0; m_req = 0; m_cmd = 0;
    end else begin
      int sidx, stag, cidx, ctag, fidx;
      bit kill, hit, filled, nr;
      sidx = int'(snp_addr) % LINES;  stag = int'(snp_addr) / LINES;
      cidx = int'(cpu_addr) % LINES;  ctag = int'(cpu_addr) / LINES;
      kill = snp_valid && (int'(snp_master) != SELF) && (snp_cmd == 2 || snp_cmd == 3)
             && m_valid[sidx] && (m_tag[sidx] == stag);
      filled = 0; nr = 0; fidx = 0;
      if (m_busy) begin
        if (bus_gnt && bus_done) begin
          fidx = m_addr % LINES;
          m_tag[fidx] = m_addr / LINES;
          filled = 1; m_busy = 0; m_req = 0; m_cmd = 0; nr = 1;
        end
      end else if (cpu_valid && !m_ready) begin
        hit = m_valid[cidx] && (m_tag[cidx] == ctag) && !(kill && sidx == cidx);
        if (!cpu_write && hit) nr = 1;
        else begin
          m_busy = 1; m_req = 1;
          m_cmd = !cpu_write ? 1 : (hit ? 3 : 2);
          m_addr = int'(cpu_addr); m_wdata = cpu_wdata;
        end
      end
      if (kill) m_valid[sidx] = 0;
      if (filled) m_valid[fidx] = 1;
      m_ready = nr;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    vectors++;
    if (cpu_ready !== m_ready) begin
      errors++; $display("FAIL %s cpu_ready actual %0b expected %0b", cur_req, cpu_ready, m_ready);
    end
    if (bus_req !== m_req) begin
      errors++; $display("FAIL %s bus_req actual %0b expected %0b", cur_req, bus_req, m_req);
    end
    if (int'(bus_cmd) != m_cmd || $isunknown(bus_cmd)) begin
      errors++; $display("FAIL %s bus_cmd actual %0d expected %0d", cur_req, bus_cmd, m_cmd);
    end
    if (m_req && int'(bus_addr) != m_addr) begin
      errors++; $display("FAIL %s bus_addr actual %0h expected %0h", cur_req, bus_addr, m_addr);
    end
    if (m_req && m_cmd == 3 && bus_wdata !== m_wdata) begin
      errors++; $display("FAIL %s bus_wdata actual %0h expected %0h", cur_req, bus_wdata, m_wdata);
    end
  end

  // bus responder: grant and done after separate delays
  always @(negedge clk) begin
    if (bus_req) begin
      resp_cnt++;
      bus_gnt  = (resp_cnt >= gnt_dly);
      bus_done = (resp_cnt >= done_dly);
    end else begin
      resp_cnt = 0; bus_gnt = 0; bus_done = 0;
    end
  end

  task automatic cpu_op(input bit wr, input int addr, input logic [DATA_W-1:0] data);
    @(negedge clk);
    cpu_valid = 1; cpu_write = wr; cpu_addr = ADDR_W'(addr); cpu_wdata = data;
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      if (cpu_ready) break;
    end
    cpu_valid = 0;
  endtask

  task automatic snoop(input int cmd, input int addr, input int master);
    @(negedge clk);
    snp_valid = 1; snp_cmd = 2'(cmd); snp_addr = ADDR_W'(addr); snp_master = ID_W'(master);
    @(negedge clk);
    snp_valid = 0;
  endtask

  localparam int A  = 12'h010;  // index 0
  localparam int A2 = 12'h0F0;  // index 0, other tag
  localparam int B  = 12'h025;  // index 5
  localparam int B2 = 12'h035;  // index 5, other tag
  localparam int C  = 12'h043;  // index 3

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);

    cur_req = "R2"; gnt_dly = 2; done_dly = 3;
    cpu_op(0, A, 0);
    cur_req = "R4"; cpu_op(0, A, 0);
    cur_req = "R5"; cpu_op(1, A, 32'hCAFE_0001);
    cur_req = "R3"; gnt_dly = 1; done_dly = 1;
    cpu_op(1, B, 32'h1234_5678);
    cur_req = "R5"; cpu_op(1, B, 32'hBEEF_0002);

    cur_req = "R6"; snoop(3, A, 2);
    cpu_op(0, A, 0);           // must miss again
    snoop(2, A, 0);            // remote read-exclusive
    cpu_op(1, A, 32'h0000_00AA); // write miss -> read-exclusive

    cur_req = "R7"; snoop(1, B, 2); snoop(3, B2, 3);
    cpu_op(1, B, 32'h7777_0003); // still a write hit
    cpu_op(0, B, 0);

    cur_req = "R8"; snoop(3, B, SELF); snoop(2, B, SELF);
    cpu_op(0, B, 0);             // still a read hit

    cur_req = "R10"; gnt_dly = 5; done_dly = 7;
    fork
      cpu_op(0, C, 0);
      begin repeat (3) @(negedge clk); snoop(2, B, 0); end
    join
    gnt_dly = 1; done_dly = 1;
    cpu_op(0, B, 0);             // killed while waiting -> miss
    cpu_op(0, A, 0);             // hit
    @(negedge clk);
    cpu_valid = 1; cpu_write = 0; cpu_addr = ADDR_W'(A);
    snp_valid = 1; snp_cmd = 2'b11; snp_addr = ADDR_W'(A); snp_master = 2'd3;
    @(negedge clk);
    snp_valid = 0;
    for (int n = 0; n < 50 && !cpu_ready; n++) @(negedge clk);
    cpu_valid = 0;

    cur_req = "R9"; gnt_dly = 2; done_dly = 9;
    cpu_op(0, A2, 0);            // replacement miss, grant long before done
    gnt_dly = 8; done_dly = 1;
    cpu_op(1, C, 32'h5555_0004); // done early, no grant yet
    gnt_dly = 1; done_dly = 1;

    cur_req = "R11";
    cpu_op(0, A2, 0); cpu_op(0, C, 0); cpu_op(0, A, 0);
    repeat (3) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule